// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address stream for a single read or write burst inside an already opened SDRAM row. A one-cycle start pulse loads a starting column, a burst-length code and a wrap-order bit. From the following clock on, the block presents one column per cycle on `col_o`. `busy_o` stays high in every cycle that carries a valid column. On the final beat of a fixed-length burst it also raises `last_o`.

Two wrap orders are supported for fixed lengths. In sequential order the low bits count upward inside the aligned block. In interleaved order the low bits are the start column XORed with the beat index. A full-page burst walks every column of the row and wraps around. It runs until the terminate input or a new start ends it. A start arriving at any time, including mid-burst, restarts the stream from the new column.

The controller has three states: `ST_IDLE`, `ST_FIXED` and `ST_PAGE`. Its transitions are:
- T_START: `ST_IDLE` to `ST_FIXED` or `ST_PAGE`.
- T_RESTART: a start taken in an active state.
- T_DONE: `ST_FIXED` to `ST_IDLE` after the final beat.
- T_STOP: an active state to `ST_IDLE` on terminate.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and in every cycle with no burst active, `busy_o`, `last_o` and `col_o` are all zero.
- R2: A start sampled at a clock edge makes the next cycle show `busy_o`=1 with `col_o` equal to the sampled start column.
- R3: With `wrap_ilv_i`=0 and a fixed length BL, beat k (k counted from 0) carries the start column with its low log2(BL) bits replaced by (start+k) mod BL; the upper bits stay unchanged.
- R4: With `wrap_ilv_i`=1 and a fixed length BL, beat k carries the start column XOR k.
- R5: `bl_code_i` values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Exactly that many consecutive cycles have `busy_o`=1, and the cycle after the last beat is idle.
- R6: `last_o` is 1 on the final beat of a fixed-length burst and 0 on every other beat. For length 1 it is 1 on the first and only beat.
- R7: `bl_code_i`=7 selects a full-page burst. Beat k carries (start+k) mod 512, so the column wraps from 511 to 0. `wrap_ilv_i` has no effect. `last_o` is never raised, and the burst continues past 512 beats.
- R8: `term_i` sampled high without a start ends the active burst, and the next cycle is idle.
- R9: A start during an active burst discards it, and the next cycle shows the new start column as beat 0 of the new burst.
- R10: When start and terminate are sampled together, the start wins.
- R11: The reserved `bl_code_i` values 4, 5 and 6 behave as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse that loads a new burst |
| start_col_i | input | 9 | Starting column |
| bl_code_i | input | 3 | Burst length code: 0/1/2/3 select 1/2/4/8 beats, 7 selects full page |
| wrap_ilv_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| term_i | input | 1 | Ends the current burst |
| col_o | output | 9 | Column address of the current beat |
| busy_o | output | 1 | A valid column is present in this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A corrupted beat counter or latched start column appears on `col_o` within the same cycle, because the column is formed combinationally from those registers. A bad length mask shows up within at most eight cycles, either as `last_o` on the wrong beat or as `busy_o` staying high one cycle too long or dropping one cycle too early. A state register stuck in the page state never raises `last_o` and never falls idle. Because every start column is swept with every fixed length and both wrap orders, such a fault becomes visible at the ports inside the first burst it affects.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] CODE_PAGE = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } sbc_state_e;

endpackage

// File: rtl/sbc_cfg_decode.sv
module sbc_cfg_decode
    import sbc_pkg::*;
#(
    parameter int COL_W       = 9,
    parameter int LEN_LOG_MAX = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  len_mask_o,
    output logic              page_o
);

    localparam int CODE_LIM = LEN_LOG_MAX;

    int unsigned len_log;

    always_comb begin
        page_o  = 1'b0;
        len_log = 0;
        if (code_i == CODE_PAGE) begin
            page_o = 1'b1;
        end else if (int'(code_i) <= CODE_LIM) begin
            len_log = int'(code_i);
        end else begin
            len_log = 0;
        end
    end

    always_comb begin
        len_mask_o = '0;
        for (int b = 0; b < COL_W; b++) begin
            if (b < int'(len_log)) len_mask_o[b] = 1'b1;
        end
    end

endmodule

// File: rtl/sbc_fsm.sv
module sbc_fsm
    import sbc_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [COL_W-1:0] len_mask_i,
    input  logic             page_i,
    input  logic             ilv_i,
    output sbc_state_e       state_o,
    output logic [COL_W-1:0] base_o,
    output logic [COL_W-1:0] mask_o,
    output logic             ilv_o,
    output logic [COL_W-1:0] cnt_o,
    output logic             busy_o,
    output logic             last_o
);

    sbc_state_e state_q, state_nx;
    logic [COL_W-1:0] base_q, mask_q, cnt_q;
    logic             ilv_q;
    logic             final_beat;

    assign final_beat = (state_q == ST_FIXED) && (cnt_q == mask_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_nx = page_i ? ST_PAGE : ST_FIXED; // T_START
            end
            ST_FIXED: begin
                if (start_i)         state_nx = page_i ? ST_PAGE : ST_FIXED; // T_RESTART
                else if (term_i)     state_nx = ST_IDLE;                     // T_STOP
                else if (final_beat) state_nx = ST_IDLE;                     // T_DONE
            end
            ST_PAGE: begin
                if (start_i)     state_nx = page_i ? ST_PAGE : ST_FIXED;     // T_RESTART
                else if (term_i) state_nx = ST_IDLE;                         // T_STOP
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // burst context and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= len_mask_i;
            ilv_q  <= ilv_i;
            cnt_q  <= '0;
        end else if (state_q != ST_IDLE) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
        base_o  = base_q;
        mask_o  = mask_q;
        ilv_o   = ilv_q;
        cnt_o   = cnt_q;
        busy_o  = (state_q != ST_IDLE);
        last_o  = final_beat;
    end

endmodule

// File: rtl/sbc_addr_map.sv
module sbc_addr_map
    import sbc_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  sbc_state_e       state_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    input  logic [COL_W-1:0] cnt_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] linear;

    assign linear = base_i + cnt_i;

    always_comb begin
        unique case (state_i)
            ST_PAGE:  col_o = linear;
            ST_FIXED: col_o = ilv_i ? (base_i ^ (cnt_i & mask_i))
                                    : ((base_i & ~mask_i) | (linear & mask_i));
            default:  col_o = '0;
        endcase
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import sbc_pkg::*;
#(
    parameter int COL_W       = 9,
    parameter int LEN_LOG_MAX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] bl_code_i,
    input  logic              wrap_ilv_i,
    input  logic              term_i,
    output logic [COL_W-1:0]  col_o,
    output logic              busy_o,
    output logic              last_o
);

    logic [COL_W-1:0] len_mask, base, mask, cnt;
    logic             page, ilv;
    sbc_state_e       state;

    sbc_cfg_decode #(.COL_W(COL_W), .LEN_LOG_MAX(LEN_LOG_MAX)) u_decode (
        .code_i     (bl_code_i),
        .len_mask_o (len_mask),
        .page_o     (page)
    );

    sbc_fsm #(.COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .term_i      (term_i),
        .start_col_i (start_col_i),
        .len_mask_i  (len_mask),
        .page_i      (page),
        .ilv_i       (wrap_ilv_i),
        .state_o     (state),
        .base_o      (base),
        .mask_o      (mask),
        .ilv_o       (ilv),
        .cnt_o       (cnt),
        .busy_o      (busy_o),
        .last_o      (last_o)
    );

    sbc_addr_map #(.COL_W(COL_W)) u_map (
        .state_i (state),
        .base_i  (base),
        .mask_i  (mask),
        .ilv_i   (ilv),
        .cnt_i   (cnt),
        .col_o   (col_o)
    );

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk
    import sbc_pkg::*;
#(
    parameter int COL_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] bl_code_i,
    input logic              term_i,
    input logic [COL_W-1:0]  col_o,
    input logic              busy_o,
    input logic              last_o
);

    logic page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       page_q <= 1'b0;
        else if (start_i) page_q <= (bl_code_i == CODE_PAGE);
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (col_o == '0) && !last_o);

    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o && (col_o == $past(start_col_i)));

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !busy_o);

    p_last_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> busy_o);

    p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && page_q && !start_i && !term_i |=>
            busy_o && (col_o == ($past(col_o) + {{(COL_W-1){1'b0}}, 1'b1})));

    p_page_nolast_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && page_q |-> !last_o);

    p_term_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_i && !start_i |=> !busy_o);

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .bl_code_i   (bl_code_i),
    .term_i      (term_i),
    .col_o       (col_o),
    .busy_o      (busy_o),
    .last_o      (last_o)
);

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       wrap_ilv_i = 1'b0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       busy_o, last_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sdram_burst_colgen u_sdram_burst_colgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .bl_code_i   (bl_code_i),
        .wrap_ilv_i  (wrap_ilv_i),
        .term_i      (term_i),
        .col_o       (col_o),
        .busy_o      (busy_o),
        .last_o      (last_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_col(input int s, input int k, input int len,
                                   input bit ilv, input bit page);
        int m;
        if (page) return (s + k) % 512;
        m = len - 1;
        if (ilv) return s ^ k;
        return (s & ~m & 511) | ((s + k) & m);
    endfunction

    // drive a start at a falling edge; returns at the falling edge where beat 0 is visible
    task automatic launch(input int s, input int code, input bit ilv, input bit trm);
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = s[8:0];
        bl_code_i   = code[2:0];
        wrap_ilv_i  = ilv;
        term_i      = trm;
        @(negedge clk);
        start_i = 1'b0;
        term_i  = 1'b0;
    endtask

    task automatic check_beat(input int s, input int k, input int len,
                              input bit ilv, input bit page);
        int e;
        e = exp_col(s, k, len, ilv, page);
        if (page)     chk(int'(col_o) == e, "R7 page column", int'(col_o), e);
        else if (ilv) chk(int'(col_o) == e, "R4 interleaved column", int'(col_o), e);
        else          chk(int'(col_o) == e, "R3 sequential column", int'(col_o), e);
        chk(busy_o == 1'b1, "R5 busy during beat", int'(busy_o), 1);
        chk(last_o == (!page && k == len - 1), "R6 last flag", int'(last_o),
            int'(!page && k == len - 1));
    endtask

    task automatic check_idle(input string tag);
        chk(busy_o == 1'b0 && last_o == 1'b0 && col_o == 9'd0, tag,
            int'({busy_o, last_o, col_o}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset state");

        // full sweep: every start column, every fixed length, both wrap orders
        for (int code = 0; code < 4; code++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 512; s++) begin
                    int len;
                    len = 1 << code;
                    launch(s, code, w[0], 1'b0);
                    chk(int'(col_o) == s, "R2 first column", int'(col_o), s);
                    for (int k = 0; k < len; k++) begin
                        check_beat(s, k, len, w[0], 1'b0);
                        @(negedge clk);
                    end
                    check_idle("R5 idle after final beat");
                end
            end
        end

        // full page bursts, wrap bit ignored, run past 512 beats then terminate
        for (int t = 0; t < 3; t++) begin
            int s;
            s = (t == 0) ? 0 : ((t == 1) ? 510 : 257);
            launch(s, 7, t[0], 1'b0);
            for (int k = 0; k < 520; k++) begin
                check_beat(s, k, 512, t[0], 1'b1);
                if (k == 519) term_i = 1'b1;
                @(negedge clk);
            end
            term_i = 1'b0;
            check_idle("R8 idle after page terminate");
        end

        // terminate a fixed burst early
        launch(40, 3, 1'b0, 1'b0);
        check_beat(40, 0, 8, 1'b0, 1'b0);
        @(negedge clk);
        check_beat(40, 1, 8, 1'b0, 1'b0);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        check_idle("R8 idle after fixed terminate");

        // restart mid burst
        launch(10, 3, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            check_beat(10, k, 8, 1'b0, 1'b0);
            if (k < 2) @(negedge clk);
        end
        start_i = 1'b1; start_col_i = 9'd301; bl_code_i = 3'd2; wrap_ilv_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(int'(col_o) == 301, "R9 restart column", int'(col_o), 301);
        for (int k = 0; k < 4; k++) begin
            check_beat(301, k, 4, 1'b1, 1'b0);
            @(negedge clk);
        end
        check_idle("R9 idle after restarted burst");

        // start and terminate together during a page burst
        launch(100, 7, 1'b0, 1'b0);
        check_beat(100, 0, 512, 1'b0, 1'b1);
        launch(200, 1, 1'b0, 1'b1);
        chk(busy_o == 1'b1 && int'(col_o) == 200, "R10 start beats terminate",
            int'(col_o), 200);
        check_beat(200, 0, 2, 1'b0, 1'b0);
        @(negedge clk);
        check_beat(200, 1, 2, 1'b0, 1'b0);
        @(negedge clk);
        check_idle("R10 idle after burst");

        // reserved codes act as length one
        for (int code = 4; code < 7; code++) begin
            launch(77 + code, code, 1'b1, 1'b0);
            chk(last_o == 1'b1 && int'(col_o) == 77 + code, "R11 reserved code single beat",
                int'(col_o), 77 + code);
            @(negedge clk);
            check_idle("R11 idle after reserved code");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule